// File: doc/BRIEF.md
# PWM Counter with Half-Clock Mode

This block is a 16-bit up-counter that produces a pulse-width-modulated level. Two compare values control it. Compare B sets the period. Compare A sets the point where the output level drops. A prescaler outside the block supplies two signals. The first is a one-cycle count tick at the start of each count-clock period. The second is a phase level that is low during the first half of that period and high during the second half. A single control word carries five settings: run, counter clear, one-shot mode, compare buffering and half-clock mode. The same word reads back on a separate output.

In normal mode, compare A is checked against the counter once per count-clock period. In half-clock mode it is checked against a dual count instead. The dual count is the counter shifted left by one bit, with the phase level as its lowest bit. Compare A is therefore evaluated on both halves of every count-clock period, which doubles the resolution of the duty cycle. When buffering is on, compare writes are held in a shadow register until the next period wrap. This lets software change the duty cycle or the period without producing a broken cycle.

Top module: `pwm_halfclk_top`

## Requirements
- R1: After reset, `count` is 0, `ctl_rdata` is 0, `pwm_out` is 1 and `cmpa_match` is 0.
- R2: The control word uses these bits: bit 0 is run, bit 1 is clear, bit 2 is one-shot, bit 3 is buffer enable and bit 4 is half mode. A write stores bits 0, 2, 3 and 4. `ctl_rdata` returns those four bits, while bit 1 and bits 7:5 always read 0.
- R3: While run is 1, `count` increases by one in the cycle after each tick. The exception is a tick that finds `count` equal to compare B. While run is 0, `count` holds its value.
- R4: A control write with bit 1 set makes `count` 0 and `pwm_out` 1 in the next cycle, whether or not a tick arrives. A control write with bit 1 clear leaves `count` unchanged.
- R5: In repeat mode (one-shot = 0), a running tick that finds `count` equal to compare B makes `count` 0 in the next cycle.
- R6: In one-shot mode, a running tick that finds `count` equal to compare B holds `count`, and run reads 0 from the next cycle. If a control write occurs in that same cycle, the written value wins.
- R7: With half mode off, `cmpa_match` is high for exactly one cycle after each running tick that finds `count` equal to compare A.
- R8: With half mode on, the dual count is {count[14:0], phase}. `cmpa_match` pulses in two cases: one cycle after a rising edge of phase when {count[14:0],0} equals compare A, and one cycle after a tick when {count[14:0],1} equals compare A.
- R9: `pwm_out` falls in the cycle after a compare-A match. It rises in the cycle after a repeat wrap or a clear. A wrap in the same cycle as a match wins.
- R10: A compare write selects its register with `cmp_sel` (0 = A, 1 = B). With buffering off, the new value applies from the next cycle.
- R11: With buffering on, a compare write only reaches the shadow register. A repeat wrap copies both shadow registers into the active registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One-cycle pulse at the start of each count-clock period |
| cnt_phase | input | 1 | Count-clock half: 0 for the first half, 1 for the second |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_sel | input | 1 | Compare register select: 0 = A, 1 = B |
| cmp_wdata | input | 16 | Compare write data |
| count | output | 16 | Counter value |
| cmpa_match | output | 1 | One-cycle compare-A match pulse |
| pwm_out | output | 1 | PWM level |
| ctl_rdata | output | 8 | Control word read-back |

## Verification
The bound checker tests several rules on every cycle. It confirms that the counter holds while stopped and steps by one on a running tick. It confirms that a clear forces zero with the output high, that a repeat wrap returns the counter to zero, that one-shot mode halts at compare B and drops run, and that no match pulse appears unless run was set. Other behaviours only show up through the bench's reference model across its scenarios. These are the dual-count match points in half mode, the exact falling edge of the PWM level, the wrap-over-match priority, and the delayed transfer from the shadow registers.

// File: rtl/pwm_halfclk_pkg.sv
package pwm_halfclk_pkg;
  localparam int CTL_RUN     = 0;
  localparam int CTL_CLR     = 1;
  localparam int CTL_ONESHOT = 2;
  localparam int CTL_BUF     = 3;
  localparam int CTL_HALF    = 4;
  localparam int CTL_USED    = 5;

  typedef struct packed {
    logic run;
    logic one_shot;
    logic buf_en;
    logic half_mode;
  } pwm_ctl_t;
endpackage

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs
  import pwm_halfclk_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             done,
  output pwm_ctl_t         ctl,
  output logic             clr
);
  pwm_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) begin
      ctl_d.run       = wdata[CTL_RUN];
      ctl_d.one_shot  = wdata[CTL_ONESHOT];
      ctl_d.buf_en    = wdata[CTL_BUF];
      ctl_d.half_mode = wdata[CTL_HALF];
    end else if (done) begin
      ctl_d.run = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;
  assign clr = wr & wdata[CTL_CLR];
endmodule

// File: rtl/pwm_cmp_slot.sv
module pwm_cmp_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buf_en,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow_q, shadow_d, active_q, active_d;
  logic         act_en, sh_en;

  always_comb begin
    sh_en    = wr;
    shadow_d = wdata;
    act_en   = (wr & ~buf_en) | (load & buf_en);
    active_d = buf_en ? shadow_q : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (sh_en)  shadow_q <= shadow_d;
      if (act_en) active_q <= active_d;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         one_shot,
  input  logic         half_mode,
  input  logic         clr,
  input  logic         tick,
  input  logic         phase,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] count,
  output logic         wrap,
  output logic         done,
  output logic         match,
  output logic         pwm
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         pwm_q, pwm_d, match_q, phase_q;
  logic         step, at_b, hit, ph_rise;
  logic [W-1:0] dual_even, dual_odd;

  always_comb begin
    step      = run & tick & ~clr;
    at_b      = step & (cnt_q == cmp_b);
    wrap      = at_b & ~one_shot;
    done      = at_b & one_shot;
    ph_rise   = phase & ~phase_q;
    dual_even = {cnt_q[W-2:0], 1'b0};
    dual_odd  = {cnt_q[W-2:0], 1'b1};
    if (half_mode)
      hit = run & ~clr & ((ph_rise & (dual_even == cmp_a)) |
                          (tick & (dual_odd == cmp_a)));
    else
      hit = step & (cnt_q == cmp_a);

    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (step & ~at_b) cnt_d = cnt_q + W'(1);

    pwm_d = pwm_q;
    if (clr | wrap) pwm_d = 1'b1;
    else if (hit)   pwm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pwm_q   <= 1'b1;
      match_q <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pwm_q   <= pwm_d;
      match_q <= hit;
      phase_q <= phase;
    end
  end

  assign count = cnt_q;
  assign match = match_q;
  assign pwm   = pwm_q;
endmodule

// File: rtl/pwm_halfclk_top.sv
module pwm_halfclk_top
  import pwm_halfclk_pkg::*;
#(
  parameter int W     = 16,
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             cnt_phase,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cmp_wr,
  input  logic             cmp_sel,
  input  logic [W-1:0]     cmp_wdata,
  output logic [W-1:0]     count,
  output logic             cmpa_match,
  output logic             pwm_out,
  output logic [CTL_W-1:0] ctl_rdata
);
  localparam int N_CMP = 2;

  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  pwm_ctl_t     ctl;
  logic         clr, wrap, done;
  logic [W-1:0] cmp_act [N_CMP];
  logic [W-1:0] cmp_a_act, cmp_b_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pwm_ctl_regs #(.CTL_W(CTL_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .done(done), .ctl(ctl), .clr(clr)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    pwm_cmp_slot #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_sync_n),
      .wr(cmp_wr & (cmp_sel == g[0])), .wdata(cmp_wdata),
      .buf_en(ctl.buf_en), .load(wrap), .active(cmp_act[g])
    );
  end
  assign cmp_a_act = cmp_act[0];
  assign cmp_b_act = cmp_act[1];

  pwm_cnt_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .run(ctl.run), .one_shot(ctl.one_shot),
    .half_mode(ctl.half_mode), .clr(clr), .tick(cnt_tick), .phase(cnt_phase),
    .cmp_a(cmp_a_act), .cmp_b(cmp_b_act), .count(count), .wrap(wrap),
    .done(done), .match(cmpa_match), .pwm(pwm_out)
  );

  always_comb begin
    ctl_rdata              = '0;
    ctl_rdata[CTL_RUN]     = ctl.run;
    ctl_rdata[CTL_ONESHOT] = ctl.one_shot;
    ctl_rdata[CTL_BUF]     = ctl.buf_en;
    ctl_rdata[CTL_HALF]    = ctl.half_mode;
  end
endmodule

// File: rtl/pwm_halfclk_chk.sv
module pwm_halfclk_chk
  import pwm_halfclk_pkg::*;
#(
  parameter int W     = 16,
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [W-1:0]     count,
  input logic             cmpa_match,
  input logic             pwm_out,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic [W-1:0]     b_act
);
  logic clr_req, running;
  assign clr_req = ctl_wr & ctl_wdata[CTL_CLR];
  assign running = ctl_rdata[CTL_RUN];

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clr_req) |=> $stable(count));

  a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_tick && !clr_req && count != b_act) |=> count == $past(count) + W'(1));

  a_r4_clear_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (count == '0 && pwm_out));

  a_r5_repeat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ctl_rdata[CTL_ONESHOT] && cnt_tick && !clr_req && count == b_act)
    |=> (count == '0 && pwm_out));

  a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ctl_rdata[CTL_ONESHOT] && cnt_tick && !ctl_wr && count == b_act)
    |=> (!ctl_rdata[CTL_RUN] && $stable(count)));

  a_r7_match_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    cmpa_match |-> $past(running));
endmodule

bind pwm_halfclk_top pwm_halfclk_chk #(.W(W), .CTL_W(CTL_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .cnt_tick(cnt_tick), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata), .count(count), .cmpa_match(cmpa_match),
  .pwm_out(pwm_out), .ctl_rdata(ctl_rdata), .b_act(cmp_b_act)
);

// File: tb/test_pwm_halfclk_top.sv
module test_pwm_halfclk_top;
  localparam int W = 16, CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cnt_tick, cnt_phase, ctl_wr, cmp_wr, cmp_sel;
  logic [CW-1:0] ctl_wdata, ctl_rdata;
  logic [W-1:0]  cmp_wdata, count;
  logic cmpa_match, pwm_out;

  always #2 clk = ~clk;

  pwm_halfclk_top #(.W(W), .CTL_W(CW)) i_pwm_halfclk_top (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_phase(cnt_phase),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cmp_wr(cmp_wr), .cmp_sel(cmp_sel),
    .cmp_wdata(cmp_wdata), .count(count), .cmpa_match(cmpa_match),
    .pwm_out(pwm_out), .ctl_rdata(ctl_rdata)
  );

  // reference model state
  logic m_run, m_os, m_bf, m_hm, m_pwm, m_pls, m_hpq;
  logic [W-1:0] m_cnt, m_aa, m_ab, m_sa, m_sb;
  int checks = 0, errors = 0, ph = 0;
  string tag = "";

  task automatic chk(string what, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] exp_ctl(logic r, logic o, logic b, logic h);
    logic [CW-1:0] v = '0;
    v[0] = r; v[2] = o; v[3] = b; v[4] = h;
    return v;
  endfunction

  function automatic logic exp_hit(logic run, logic hm, logic clr, logic tick,
                                   logic rise, logic [W-1:0] c, logic [W-1:0] a);
    if (!run || clr) return 1'b0;
    if (!hm) return tick && (c == a);
    return (rise && ({c[W-2:0], 1'b0} == a)) || (tick && ({c[W-2:0], 1'b1} == a));
  endfunction

  task automatic model_step();
    logic clr, hit, atb, wrap, done;
    clr  = ctl_wr && ctl_wdata[1];
    hit  = exp_hit(m_run, m_hm, clr, cnt_tick, cnt_phase && !m_hpq, m_cnt, m_aa);
    atb  = m_run && cnt_tick && !clr && (m_cnt == m_ab);
    wrap = atb && !m_os;
    done = atb && m_os;
    // R9 level, R7/R8 pulse
    if (clr || wrap) m_pwm = 1'b1; else if (hit) m_pwm = 1'b0;
    m_pls = hit;
    // R3/R4/R5/R6 count
    if (clr) m_cnt = '0;
    else if (m_run && cnt_tick) m_cnt = (m_cnt == m_ab) ? (m_os ? m_cnt : '0) : m_cnt + 1'b1;
    // R10/R11 compare registers
    if (wrap && m_bf) begin m_aa = m_sa; m_ab = m_sb; end
    if (cmp_wr) begin
      if (!cmp_sel) begin m_sa = cmp_wdata; if (!m_bf) m_aa = cmp_wdata; end
      else          begin m_sb = cmp_wdata; if (!m_bf) m_ab = cmp_wdata; end
    end
    // R2 control
    if (ctl_wr) begin
      m_run = ctl_wdata[0]; m_os = ctl_wdata[2]; m_bf = ctl_wdata[3]; m_hm = ctl_wdata[4];
    end else if (done) m_run = 1'b0;
    m_hpq = cnt_phase;
  endtask

  task automatic cycle();
    cnt_tick  = (ph == 0);
    cnt_phase = (ph >= 2);
    ph = (ph + 1) % 4;
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R3/R5 count", count, m_cnt);
    chk("R9 pwm", pwm_out, m_pwm);
    chk("R7/R8 match", cmpa_match, m_pls);
    chk("R2 ctl", ctl_rdata, exp_ctl(m_run, m_os, m_bf, m_hm));
    ctl_wr = 1'b0; cmp_wr = 1'b0;
  endtask

  task automatic wr_ctl(logic r, logic c, logic o, logic b, logic h);
    ctl_wr = 1'b1;
    ctl_wdata = '0;
    ctl_wdata[0] = r; ctl_wdata[1] = c; ctl_wdata[2] = o; ctl_wdata[3] = b; ctl_wdata[4] = h;
    cycle();
  endtask

  task automatic wr_cmp(logic s, logic [W-1:0] v);
    cmp_wr = 1'b1; cmp_sel = s; cmp_wdata = v;
    cycle();
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    cnt_tick = 0; cnt_phase = 0; ctl_wr = 0; cmp_wr = 0; cmp_sel = 0;
    ctl_wdata = '0; cmp_wdata = '0;
    m_run = 0; m_os = 0; m_bf = 0; m_hm = 0; m_pwm = 1; m_pls = 0; m_hpq = 0;
    m_cnt = '0; m_aa = '0; m_ab = '0; m_sa = '0; m_sb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    tag = "R1 reset";
    chk("count", count, 0);
    chk("ctl", ctl_rdata, 0);
    chk("pwm", pwm_out, 1);
    chk("match", cmpa_match, 0);

    tag = "R10 unbuffered";
    wr_cmp(1'b1, 16'd5);
    wr_cmp(1'b0, 16'd2);
    wr_ctl(1, 0, 0, 0, 0);
    run_n(60);

    tag = "R2 reserved";
    ctl_wr = 1'b1; ctl_wdata = 8'hE2; cycle();
    chk("R2 readback of reserved bits", ctl_rdata, 0);

    tag = "R4 clear";
    wr_ctl(1, 0, 0, 0, 0);
    run_n(13);
    wr_ctl(1, 1, 0, 0, 0);
    chk("R4 count after clear", count, 0);
    run_n(9);
    wr_ctl(1, 0, 0, 0, 0);
    chk("R4 count kept without clear bit", count, m_cnt);

    tag = "R6 one-shot";
    wr_cmp(1'b1, 16'd3);
    wr_ctl(1, 1, 1, 0, 0);
    run_n(40);
    chk("R6 count holds at compare B", count, 3);
    chk("R6 run bit dropped", ctl_rdata[0], 0);

    tag = "R8 half mode";
    wr_cmp(1'b1, 16'd7);
    wr_cmp(1'b0, 16'd5);
    wr_ctl(1, 1, 0, 0, 1);
    run_n(80);
    wr_cmp(1'b0, 16'd8);
    run_n(80);

    tag = "R11 buffered";
    wr_ctl(1, 1, 0, 1, 0);
    wr_cmp(1'b1, 16'd11);
    wr_cmp(1'b0, 16'd4);
    run_n(120);

    tag = "R7 random";
    for (int i = 0; i < 20000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 3) begin
        ctl_wr = 1'b1;
        ctl_wdata = CW'($urandom);
        ctl_wdata[0] = ($urandom % 4) != 0;
        ctl_wdata[1] = ($urandom % 4) == 0;
      end else if (r < 8) begin
        cmp_wr = 1'b1;
        cmp_sel = $urandom % 2;
        cmp_wdata = cmp_sel ? W'($urandom % 16) : W'($urandom % 40);
      end
      cycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule